// File: doc/BRIEF.md
# Piecewise-Linear Gamma Corrector

This block takes a stream of 10-bit video samples and bends each one onto an 8-bit output curve made of ten straight segments. Nine programmable breakpoints cut the input axis into ten ranges. Each range has its own 8-bit slope and 8-bit offset. A polarity bit decides whether a segment's ramp is added to its offset or taken away from it. One sample can enter on every clock. Its result leaves two clocks later, with a valid flag that follows it through the pipeline.

Coefficients arrive through a plain write port and go into a shadow set. They reach the datapath only on a frame-start strobe. The curve in use therefore changes only between frames, and each frame is processed with a single consistent curve.

Top module: `pwl_gamma_corrector`

## Requirements
- R1: After synchronous reset, `out_vld` and `out_pix` are 0 and every coefficient is zero, live and shadow alike. With that curve, every valid sample produces 0.
- R2: `out_vld` equals `pix_vld` from two clocks earlier, and `out_pix` belongs to the sample accepted in that cycle. Gaps in the input stream leave gaps in the output.
- R3: With x = `pix_in[9:2]`, the segment used is the lowest index k (0..8) whose breakpoint is greater than x. If no breakpoint is greater than x, segment 9 is used.
- R4: Segment 0 starts at input 0. Segment k > 0 starts at input 4 × breakpoint[k-1]. The ramp term is ((pix_in − start) × slope[k] + 32) >> 6.
- R5: When the polarity bit is 0, the output is offset[k] + ramp, clamped to 255.
- R6: When the polarity bit is 1, the output is offset[k] − ramp, clamped to 0.
- R7: Address map of the write port: 0..8 hold breakpoints 0..8, 16..25 hold slopes 0..9, 32..41 hold offsets 0..9, and bit 0 of address 48 holds the polarity. Writes to any other address change nothing.
- R8: Writes go to the shadow set only. The output curve stays the same until `frame_start` is sampled high, and from the next sample onward the output follows the shadow set.
- R9: A write presented in the same cycle as `frame_start` is not part of the curve that strobe takes live. It goes live at the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Coefficient write strobe |
| cfg_addr | input | 6 | Coefficient write address |
| cfg_data | input | 8 | Coefficient write data |
| frame_start | input | 1 | Copies the shadow coefficients into the live set |
| pix_vld | input | 1 | Input sample valid |
| pix_in | input | 10 | Input sample |
| out_vld | output | 1 | Output sample valid |
| out_pix | output | 8 | Corrected output sample |

## Verification
The main function is tried in four settings. With all coefficients zero, any error in offset or ramp shows as a non-zero output. With rising breakpoints and a positive polarity, a full 0..1023 sweep crosses every segment edge and drives the upper segments into the 255 clamp. The same sweep with negative polarity drives them into the 0 clamp. A partial sweep after stray writes to unmapped addresses shows whether the address decoder leaks. The valid pattern has regular holes, so a wrong latency or a dropped valid shows as a mismatch. Writes made without a strobe, and a write made in the strobe cycle, show whether the shadow set and the live set are kept apart.

// File: rtl/gamma_pkg.sv
package gamma_pkg;
    localparam int PIX_W    = 10;
    localparam int CO_W     = 8;
    localparam int OUT_W    = CO_W;
    localparam int NSEG     = 10;
    localparam int NBP      = NSEG - 1;
    localparam int FRAC     = 6;
    localparam int ROUND    = 1 << (FRAC - 1);
    localparam int SEG_W    = $clog2(NSEG);
    localparam int ADDR_W   = 6;
    localparam int BP_BASE  = 0;
    localparam int SL_BASE  = 16;
    localparam int OF_BASE  = 32;
    localparam int POL_ADDR = 48;
    localparam int PROD_W   = PIX_W + CO_W;
    localparam int SCL_W    = PROD_W - FRAC + 1;
    localparam int PAD_W    = PIX_W - CO_W;

    typedef struct packed {
        logic [NBP-1:0][CO_W-1:0]  bp;
        logic [NSEG-1:0][CO_W-1:0] slope;
        logic [NSEG-1:0][CO_W-1:0] offset;
        logic                      neg;
    } curve_t;

    typedef struct packed {
        logic              vld;
        logic [PIX_W-1:0]  delta;
        logic [CO_W-1:0]   slope;
        logic [CO_W-1:0]   offset;
        logic              neg;
    } seg_stage_t;

    function automatic logic [OUT_W-1:0] pwl_eval(
        input logic [PIX_W-1:0] d,
        input logic [CO_W-1:0]  s,
        input logic [CO_W-1:0]  o,
        input logic             n
    );
        logic [PROD_W:0]  rnd;
        logic [SCL_W-1:0] sc;
        logic [SCL_W:0]   acc;
        logic [SCL_W:0]   lim;
        rnd = (PROD_W+1)'(d) * (PROD_W+1)'(s) + (PROD_W+1)'(ROUND);
        sc  = rnd[PROD_W:FRAC];
        lim = (SCL_W+1)'((1 << OUT_W) - 1);
        if (!n) begin
            acc = (SCL_W+1)'(o) + (SCL_W+1)'(sc);
            return (acc > lim) ? lim[OUT_W-1:0] : acc[OUT_W-1:0];
        end
        if (SCL_W'(o) < sc) return '0;
        return o - sc[OUT_W-1:0];
    endfunction
endpackage

// File: rtl/gamma_coef_bank.sv
module gamma_coef_bank
    import gamma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CO_W-1:0]   wr_data,
    input  logic              frame_start,
    output curve_t            live
);
    curve_t          shadow;
    logic [NBP-1:0]  bp_we;
    logic [NSEG-1:0] sl_we;
    logic [NSEG-1:0] of_we;
    logic            pol_we;

    for (genvar g = 0; g < NBP; g++) begin : g_bp_dec
        assign bp_we[g] = wr_en && (wr_addr == ADDR_W'(BP_BASE + g));
    end
    for (genvar g = 0; g < NSEG; g++) begin : g_seg_dec
        assign sl_we[g] = wr_en && (wr_addr == ADDR_W'(SL_BASE + g));
        assign of_we[g] = wr_en && (wr_addr == ADDR_W'(OF_BASE + g));
    end
    assign pol_we = wr_en && (wr_addr == ADDR_W'(POL_ADDR));

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= '0;
        end else begin
            for (int i = 0; i < NBP; i++)
                if (bp_we[i]) shadow.bp[i] <= wr_data;
            for (int i = 0; i < NSEG; i++) begin
                if (sl_we[i]) shadow.slope[i]  <= wr_data;
                if (of_we[i]) shadow.offset[i] <= wr_data;
            end
            if (pol_we) shadow.neg <= wr_data[0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)              live <= '0;
        else if (frame_start) live <= shadow;
    end

    // R8
    live_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> $stable(live));
    // R9
    live_take_chk: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> (live == $past(shadow)));
endmodule

// File: rtl/gamma_seg_select.sv
module gamma_seg_select
    import gamma_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_vld,
    input  logic [PIX_W-1:0] in_pix,
    input  curve_t           curve,
    output seg_stage_t       stage_q
);
    logic [NBP-1:0]   hit;
    logic [SEG_W-1:0] seg;
    logic [PIX_W-1:0] start;

    for (genvar g = 0; g < NBP; g++) begin : g_cmp
        assign hit[g] = curve.bp[g] > in_pix[PIX_W-1 -: CO_W];
    end

    always_comb begin
        seg = SEG_W'(NBP);
        for (int j = NBP - 1; j >= 0; j--)
            if (hit[j]) seg = SEG_W'(j);
        if (seg == '0) start = '0;
        else           start = {curve.bp[seg - SEG_W'(1)], {PAD_W{1'b0}}};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else begin
            stage_q.vld <= in_vld;
            if (in_vld) begin
                stage_q.delta  <= in_pix - start;
                stage_q.slope  <= curve.slope[seg];
                stage_q.offset <= curve.offset[seg];
                stage_q.neg    <= curve.neg;
            end
        end
    end

    // R2
    stage_vld_chk: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> stage_q.vld);
    // R2
    stage_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> !stage_q.vld);
endmodule

// File: rtl/gamma_eval.sv
module gamma_eval
    import gamma_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  seg_stage_t       st,
    output logic             out_vld,
    output logic [OUT_W-1:0] out_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld  <= 1'b0;
            out_data <= '0;
        end else begin
            out_vld <= st.vld;
            if (st.vld)
                out_data <= pwl_eval(st.delta, st.slope, st.offset, st.neg);
        end
    end

    // R5
    pos_floor_chk: assert property (@(posedge clk) disable iff (rst)
        (st.vld && !st.neg) |=> (out_data >= $past(st.offset)));
    // R6
    neg_ceil_chk: assert property (@(posedge clk) disable iff (rst)
        (st.vld && st.neg) |=> (out_data <= $past(st.offset)));
    // R4
    flat_seg_chk: assert property (@(posedge clk) disable iff (rst)
        (st.vld && st.slope == '0) |=> (out_data == $past(st.offset)));
    // R2
    out_vld_chk: assert property (@(posedge clk) disable iff (rst)
        st.vld |=> out_vld);
endmodule

// File: rtl/pwl_gamma_corrector.sv
module pwl_gamma_corrector
    import gamma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [CO_W-1:0]   cfg_data,
    input  logic              frame_start,
    input  logic              pix_vld,
    input  logic [PIX_W-1:0]  pix_in,
    output logic              out_vld,
    output logic [OUT_W-1:0]  out_pix
);
    curve_t     live;
    seg_stage_t stage;

    gamma_coef_bank u_bank (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (cfg_wr),
        .wr_addr     (cfg_addr),
        .wr_data     (cfg_data),
        .frame_start (frame_start),
        .live        (live)
    );

    gamma_seg_select u_sel (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (pix_vld),
        .in_pix  (pix_in),
        .curve   (live),
        .stage_q (stage)
    );

    gamma_eval u_eval (
        .clk      (clk),
        .rst      (rst),
        .st       (stage),
        .out_vld  (out_vld),
        .out_data (out_pix)
    );

    // R1
    rst_quiet_chk: assert property (@(posedge clk)
        rst |=> (!out_vld && out_pix == '0));
endmodule

// File: tb/pwl_gamma_corrector_test.sv
module pwl_gamma_corrector_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_wr = 1'b0;
    logic [5:0] cfg_addr = '0;
    logic [7:0] cfg_data = '0;
    logic       frame_start = 1'b0;
    logic       pix_vld = 1'b0;
    logic [9:0] pix_in = '0;
    logic       out_vld;
    logic [7:0] out_pix;

    int n_chk = 0;
    int n_fail = 0;
    string cur_req = "R1";
    bit cmp_en = 1'b0;

    int sh_bp[9], sh_sl[10], sh_of[10], sh_neg;
    int ac_bp[9], ac_sl[10], ac_of[10], ac_neg;
    bit e_v1 = 0, e_v2 = 0;
    int e_d1 = 0, e_d2 = 0;

    always #10 clk = ~clk;

    pwl_gamma_corrector uut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .frame_start(frame_start), .pix_vld(pix_vld),
        .pix_in(pix_in), .out_vld(out_vld), .out_pix(out_pix)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ref_out(input int pix);
        int x, k, st, r;
        x = pix >> 2;
        k = 9;
        for (int j = 8; j >= 0; j--) if (ac_bp[j] > x) k = j;
        st = (k == 0) ? 0 : ac_bp[k-1] * 4;
        r = ((pix - st) * ac_sl[k] + 32) >> 6;
        if (ac_neg == 0) return (ac_of[k] + r > 255) ? 255 : ac_of[k] + r;
        return (r > ac_of[k]) ? 0 : ac_of[k] - r;
    endfunction

    // reference model, advanced on every rising edge
    always @(posedge clk) begin
        if (rst) begin
            e_v1 = 0; e_v2 = 0; e_d1 = 0; e_d2 = 0;
            for (int i = 0; i < 10; i++) begin
                sh_sl[i] = 0; sh_of[i] = 0; ac_sl[i] = 0; ac_of[i] = 0;
                if (i < 9) begin sh_bp[i] = 0; ac_bp[i] = 0; end
            end
            sh_neg = 0; ac_neg = 0;
        end else begin
            if (e_v1) e_d2 = e_d1;
            e_v2 = e_v1;
            e_v1 = pix_vld;
            if (pix_vld) e_d1 = ref_out(int'(pix_in));
            if (frame_start) begin
                ac_bp = sh_bp; ac_sl = sh_sl; ac_of = sh_of; ac_neg = sh_neg;
            end
            if (cfg_wr) begin
                if (cfg_addr <= 8) sh_bp[cfg_addr] = cfg_data;
                else if (cfg_addr >= 16 && cfg_addr <= 25) sh_sl[cfg_addr-16] = cfg_data;
                else if (cfg_addr >= 32 && cfg_addr <= 41) sh_of[cfg_addr-32] = cfg_data;
                else if (cfg_addr == 48) sh_neg = cfg_data[0];
            end
        end
    end

    // per-cycle compare against the model
    always @(negedge clk) begin
        if (cmp_en && !rst) begin
            chk(out_vld == e_v2, "R2 valid", out_vld, e_v2);
            if (e_v2) chk(out_pix == e_d2[7:0], cur_req, out_pix, e_d2);
        end
    end

    task automatic step(input bit wr, input int a, input int d, input bit fs,
                        input bit v, input int p);
        @(negedge clk);
        cfg_wr = wr; cfg_addr = 6'(a); cfg_data = 8'(d);
        frame_start = fs; pix_vld = v; pix_in = 10'(p);
    endtask

    task automatic wr(input int a, input int d);
        step(1, a, d, 0, 0, 0);
    endtask

    task automatic sweep(input int lo, input int hi);
        for (int i = lo; i <= hi; i++) step(0, 0, 0, 0, (i % 4) != 3, i);
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 0);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state seen at the ports
        chk(out_vld == 1'b0, "R1 vld", out_vld, 0);
        chk(out_pix == 8'd0, "R1 pix", out_pix, 0);
        @(negedge clk); rst = 1'b0;
        cmp_en = 1'b1;
        cur_req = "R1 zero curve";
        sweep(0, 63);

        // R8: load a rising curve without a strobe; output must stay 0
        for (int j = 0; j < 9; j++) wr(j, 25 * (j + 1));
        for (int k = 0; k < 10; k++) begin
            wr(16 + k, 20 + 20 * k);
            wr(32 + k, 25 * k);
        end
        cur_req = "R8 no strobe";
        sweep(500, 627);
        step(0, 0, 0, 1, 0, 0);
        // R3 R4 R5: full sweep, positive polarity, upper segments saturate
        cur_req = "R3/R4/R5 positive";
        sweep(0, 1023);

        // R6: negative polarity, lower clamp
        for (int k = 0; k < 10; k++) begin
            wr(16 + k, 40 + 15 * k);
            wr(32 + k, 255 - 10 * k);
        end
        wr(48, 1);
        step(0, 0, 0, 1, 0, 0);
        cur_req = "R6 negative";
        sweep(0, 1023);

        // R7: writes to unmapped addresses must not change the curve
        wr(9, 255); wr(15, 255); wr(26, 255); wr(31, 255);
        wr(42, 255); wr(47, 255); wr(49, 255); wr(63, 255);
        step(0, 0, 0, 1, 0, 0);
        cur_req = "R7 unmapped";
        sweep(200, 455);

        // R9: write in the strobe cycle waits for the next strobe
        wr(48, 0);
        step(1, 32, 7, 1, 0, 0);
        cur_req = "R9 same-cycle write";
        sweep(0, 120);
        step(0, 0, 0, 1, 0, 0);
        cur_req = "R9 next strobe";
        sweep(0, 120);

        // R1: reset again clears the live curve
        step(0, 0, 0, 0, 0, 0);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        cur_req = "R1 after reset";
        sweep(300, 340);
        summary();
    end
endmodule